// File: doc/BRIEF.md
# Sticky Wake-Event Status Aggregator

This block gathers up to 32 power-management wake events into one global status flag and raises a level interrupt to the system. Each child event arrives as a status bit with its own enable bit. The 32 pairs are grouped as four bytes. If any child bit is both active and enabled in a cycle, the global status flag is set on the next clock edge. The flag then stays set until software clears it.

Software reaches two byte-wide registers through a plain strobe interface: an address, write data, a write strobe, a read strobe and combinational read data. The status register is write-one-to-clear. A clear succeeds only while no enabled child event is active. When a clear and a set condition fall in the same cycle, the set condition wins. The enable register is an ordinary read/write register. The interrupt output is high while both the status flag and the enable flag are 1.

Top module: `wake_agg_top`

## Requirements
- R1: After reset, the status flag and the enable flag are 0, `irqOut` is 0, and reads of offsets 00h and 04h return 00h.
- R2: When any bit i has both `childStatus[i]` and `childEnable[i]` at 1 in a cycle, the status flag (read at offset 00h, bit 0) is 1 after the next rising clock edge.
- R3: Once set, the status flag stays 1 after every enabled child event has gone inactive, until a successful clear.
- R4: A write to offset 00h with data bit 0 at 1, made while no enabled child event is active, clears the status flag at that clock edge.
- R5: A clearing write to offset 00h has no effect while any enabled child event is active, including in the cycle in which the flag would first be set.
- R6: A write to offset 00h with data bit 0 at 0 leaves the status flag unchanged.
- R7: The enable flag is bit 0 of offset 04h. A write loads it from data bit 0, and a read returns it.
- R8: `irqOut` is 1 exactly when the status flag and the enable flag are both 1. It falls in the cycle after a successful clear or after the enable flag is written to 0.
- R9: Bits 7 to 1 of offsets 00h and 04h always read as 0, and writes to those bits have no effect.
- R10: Reads of any offset other than 00h and 04h return 00h. Writes to such offsets change neither flag.
- R11: A child status bit whose enable bit is 0 never sets the status flag.
- R12: Every one of the 32 child positions, across all four bytes, can set the status flag on its own.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| childStatus | input | 32 | Child event status, four bytes |
| childEnable | input | 32 | Per-bit enables for the child events |
| regAddr | input | 8 | Register offset |
| regWdata | input | 8 | Write data |
| regWrite | input | 1 | Write strobe, one cycle per write |
| regRead | input | 1 | Read strobe |
| regRdata | output | 8 | Read data, valid while `regRead` is high |
| irqOut | output | 1 | Level interrupt request |

## Verification
On every cycle, the assertions check several rules. An active enabled child always leaves the flag set. A set flag holds unless a clearing write is presented. A clearing write with no enabled child active leaves the flag clear. A zero write does not disturb a clear flag. The enable flag follows the written bit. Writing the enable to 0 drops the interrupt. The behaviours that need a register read or a chosen sequence are shown only by the bench scenarios: reset values, reserved bits reading 0, unmapped offsets, a masked child, every child position, and the set condition winning against a same-cycle clear.

// File: rtl/wake_agg_pkg.sv
package wake_agg_pkg;
  // Strobes from the decode control to the register datapath
  typedef struct packed {
    logic wrSts;
    logic wrEn;
    logic rdSts;
    logic rdEn;
  } regStrobe_t;
endpackage

// File: rtl/wake_agg_ctrl.sv
module wake_agg_ctrl
  import wake_agg_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int STS_OFS = 0,
  parameter int EN_OFS  = 4
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrite,
  input  logic              regRead,
  output regStrobe_t        strb
);
  localparam logic [ADDR_W-1:0] StsAddr = ADDR_W'(STS_OFS);
  localparam logic [ADDR_W-1:0] EnAddr  = ADDR_W'(EN_OFS);

  logic hitSts;
  logic hitEn;

  always_comb begin
    hitSts     = (regAddr == StsAddr);
    hitEn      = (regAddr == EnAddr);
    strb.wrSts = regWrite && hitSts;
    strb.wrEn  = regWrite && hitEn;
    strb.rdSts = regRead && hitSts;
    strb.rdEn  = regRead && hitEn;
  end
endmodule

// File: rtl/wake_agg_dp.sv
module wake_agg_dp
  import wake_agg_pkg::*;
#(
  parameter int NUM_BYTES = 4,
  parameter int DATA_W    = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_BYTES*8-1:0]   childStatus,
  input  logic [NUM_BYTES*8-1:0]   childEnable,
  input  regStrobe_t               strb,
  input  logic                     wrBit0,
  output logic [DATA_W-1:0]        rdData,
  output logic                     stsBit,
  output logic                     enBit,
  output logic                     anyActive
);
  localparam int NumEvents = NUM_BYTES * 8;

  logic [NUM_BYTES-1:0] byteActive;

  // One reduction per child byte, then across bytes
  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    assign byteActive[b] = |(childStatus[b*8 +: 8] & childEnable[b*8 +: 8]);
  end
  assign anyActive = |byteActive;

  logic clrReq;
  assign clrReq = strb.wrSts && wrBit0;

  // Sticky status: set condition has priority over a clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stsBit <= 1'b0;
    end else if (anyActive) begin
      stsBit <= 1'b1;
    end else if (clrReq) begin
      stsBit <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enBit <= 1'b0;
    end else if (strb.wrEn) begin
      enBit <= wrBit0;
    end
  end

  // Reserved bits are constant zero
  always_comb begin
    rdData = '0;
    if (strb.rdSts) rdData[0] = stsBit;
    if (strb.rdEn)  rdData[0] = enBit;
  end

  logic [NumEvents-1:0] unusedDummy;
  assign unusedDummy = '0;

  assert_set_on_event_R2: assert property (@(posedge clk) disable iff (!rstN)
    anyActive |=> stsBit);

  assert_sticky_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stsBit && !clrReq) |=> stsBit);

  assert_clear_effect_R4: assert property (@(posedge clk) disable iff (!rstN)
    (clrReq && !anyActive) |=> !stsBit);

  assert_zero_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrSts && !wrBit0 && !stsBit && !anyActive) |=> !stsBit);

  assert_enable_load_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |=> (enBit == $past(wrBit0)));
endmodule

// File: rtl/wake_agg_top.sv
module wake_agg_top
  import wake_agg_pkg::*;
#(
  parameter int NUM_BYTES = 4,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int STS_OFS   = 0,
  parameter int EN_OFS    = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_BYTES*8-1:0] childStatus,
  input  logic [NUM_BYTES*8-1:0] childEnable,
  input  logic [ADDR_W-1:0]      regAddr,
  input  logic [DATA_W-1:0]      regWdata,
  input  logic                   regWrite,
  input  logic                   regRead,
  output logic [DATA_W-1:0]      regRdata,
  output logic                   irqOut
);
  regStrobe_t strb;
  logic stsBit;
  logic enBit;
  logic anyActive;

  // Only bit 0 of the write data is mapped
  logic unusedWdata;
  assign unusedWdata = ^regWdata[DATA_W-1:1];

  wake_agg_ctrl #(
    .ADDR_W (ADDR_W),
    .STS_OFS(STS_OFS),
    .EN_OFS (EN_OFS)
  ) ctrl_i (
    .regAddr (regAddr),
    .regWrite(regWrite),
    .regRead (regRead),
    .strb    (strb)
  );

  wake_agg_dp #(
    .NUM_BYTES(NUM_BYTES),
    .DATA_W   (DATA_W)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .childStatus(childStatus),
    .childEnable(childEnable),
    .strb       (strb),
    .wrBit0     (regWdata[0]),
    .rdData     (regRdata),
    .stsBit     (stsBit),
    .enBit      (enBit),
    .anyActive  (anyActive)
  );

  assign irqOut = stsBit && enBit;

  assert_irq_drop_on_disable_R8: assert property (@(posedge clk) disable iff (!rstN)
    (regWrite && regAddr == ADDR_W'(EN_OFS) && !regWdata[0]) |=> !irqOut);

  assert_irq_drop_on_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (regWrite && regAddr == ADDR_W'(STS_OFS) && regWdata[0] && !anyActive) |=> !irqOut);
endmodule

// File: tb/wake_agg_top_tb.sv
module wake_agg_top_tb_top;
  localparam int ClkPeriod = 10;

  logic clk = 0;
  logic rstN = 0;
  logic [31:0] childStatus = '0;
  logic [31:0] childEnable = '0;
  logic [7:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic regWrite = 0;
  logic regRead = 0;
  logic [7:0] regRdata;
  logic irqOut;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(ClkPeriod/2) clk = ~clk;

  wake_agg_top dut_i (
    .clk(clk), .rstN(rstN), .childStatus(childStatus), .childEnable(childEnable),
    .regAddr(regAddr), .regWdata(regWdata), .regWrite(regWrite), .regRead(regRead),
    .regRdata(regRdata), .irqOut(irqOut)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doWrite(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWrite = 1;
    @(negedge clk);
    regWrite = 0;
  endtask

  task automatic doRead(logic [7:0] a, output logic [7:0] d);
    regAddr = a; regRead = 1;
    #1 d = regRdata;
    regRead = 0;
  endtask

  task automatic setChild(logic [31:0] s, logic [31:0] e);
    @(negedge clk);
    childStatus = s; childEnable = e;
    @(negedge clk);
  endtask

  task automatic clearAll();
    setChild('0, '0);
    doWrite(8'h00, 8'h01);
    doWrite(8'h04, 8'h00);
  endtask

  task automatic testReset();
    logic [7:0] d;
    doRead(8'h00, d); check("R1 sts", d, 8'h00);
    doRead(8'h04, d); check("R1 en", d, 8'h00);
    check("R1 irq", irqOut, 0);
  endtask

  task automatic testSetSticky();
    logic [7:0] d;
    setChild(32'h1, 32'h1);
    doRead(8'h00, d); check("R2 set", d, 8'h01);
    setChild('0, 32'h1);
    repeat (3) @(negedge clk);
    doRead(8'h00, d); check("R3 sticky", d, 8'h01);
    clearAll();
  endtask

  task automatic testClearIrq();
    logic [7:0] d;
    setChild(32'h100, 32'h100);
    setChild('0, '0);
    doWrite(8'h04, 8'h01);
    check("R8 irq high", irqOut, 1);
    doWrite(8'h00, 8'h01);
    doRead(8'h00, d); check("R4 cleared", d, 8'h00);
    check("R8 irq low after clear", irqOut, 0);
    setChild(32'h100, 32'h100);
    setChild('0, '0);
    check("R8 irq again", irqOut, 1);
    doWrite(8'h04, 8'h00);
    check("R8 irq low after disable", irqOut, 0);
    doRead(8'h04, d); check("R7 en zero", d, 8'h00);
    clearAll();
  endtask

  task automatic testBlocked();
    logic [7:0] d;
    setChild(32'h0001_0000, 32'hFFFF_FFFF);
    doWrite(8'h00, 8'h01);
    doRead(8'h00, d); check("R5 blocked", d, 8'h01);
    setChild('0, '0);
    doWrite(8'h00, 8'h01);
    doRead(8'h00, d); check("R5 cleared after", d, 8'h00);
    // Same cycle: set condition and clearing write
    @(negedge clk);
    childStatus = 32'h2; childEnable = 32'h2;
    regAddr = 8'h00; regWdata = 8'h01; regWrite = 1;
    @(negedge clk);
    regWrite = 0; childStatus = '0;
    doRead(8'h00, d); check("R5 set wins", d, 8'h01);
    clearAll();
  endtask

  task automatic testZeroAndReserved();
    logic [7:0] d;
    setChild(32'h8, 32'h8);
    setChild('0, '0);
    doWrite(8'h00, 8'h00);
    doRead(8'h00, d); check("R6 zero write", d, 8'h01);
    doWrite(8'h00, 8'hFE);
    doRead(8'h00, d); check("R9 sts reserved", d, 8'h01);
    doWrite(8'h04, 8'hFF);
    doRead(8'h04, d); check("R7 en set", d, 8'h01);
    doWrite(8'h04, 8'hFE);
    doRead(8'h04, d); check("R9 en reserved", d, 8'h00);
    clearAll();
  endtask

  task automatic testUnmapped();
    logic [7:0] d;
    doWrite(8'h04, 8'h01);
    setChild(32'h4000, 32'h4000);
    setChild('0, '0);
    doWrite(8'h01, 8'hFF);
    doWrite(8'h05, 8'h00);
    doWrite(8'h08, 8'h00);
    doRead(8'h08, d); check("R10 read 08", d, 8'h00);
    doRead(8'h02, d); check("R10 read 02", d, 8'h00);
    doRead(8'h00, d); check("R10 sts kept", d, 8'h01);
    doRead(8'h04, d); check("R10 en kept", d, 8'h01);
    clearAll();
  endtask

  task automatic testMasked();
    logic [7:0] d;
    setChild(32'hFFFF_FFFF, 32'h0);
    repeat (2) @(negedge clk);
    doRead(8'h00, d); check("R11 masked", d, 8'h00);
    setChild(32'h5555_5555, 32'hAAAA_AAAA);
    doRead(8'h00, d); check("R11 disjoint", d, 8'h00);
    clearAll();
  endtask

  task automatic testAllPositions();
    logic [7:0] d;
    for (int i = 0; i < 32; i++) begin
      setChild(32'h1 << i, 32'h1 << i);
      doRead(8'h00, d);
      check($sformatf("R12 bit %0d", i), d, 8'h01);
      setChild('0, '0);
      doWrite(8'h00, 8'h01);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testSetSticky();
    testClearIrq();
    testBlocked();
    testZeroAndReserved();
    testUnmapped();
    testMasked();
    testAllPositions();
    done = 1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule